// File: doc/BRIEF.md
# Single-Cycle RV32I Integer Core

This block is a small processor core that completes one instruction on every clock edge: the word at the program counter is fetched, decoded, executed in the ALU, and its result is written to the register file or the data memory in that same cycle. It executes the register-register and register-immediate integer ALU operations of RV32I, together with full-word loads and stores. Branches, jumps, upper-immediate forms, fences, environment calls and sub-word memory accesses are not executed here. Sub-word accesses belong to a separate block.

Instruction memory, data memory and the register file sit inside the core. While the `run` input is low the core is frozen, and a simple load port fills any of the three storage arrays. A combinational read port returns any register, so the final machine state can be inspected once a program has finished. The instruction memory is addressed by word, from PC bits upward of bit 2. The data memory holds one 32-bit word per address value. Addresses wrap modulo the data memory depth.

Top module: `rv_sc_core`

## Requirements
- R1: Reset (active-low `rst_n`) clears the PC and all registers to 0. While `run` is 1 the PC rises by exactly 4 on every clock edge. While `run` is 0 the PC holds its value.
- R2: Opcode 0110011 selects an R-type operation from funct3: 000 add or sub, 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 xor, 101 logical or arithmetic right shift, 110 or, 111 and. Instruction bit 30 set selects sub for funct3 000 and the arithmetic right shift for funct3 101.
- R3: Every R-type instruction, every I-type ALU instruction and every word load writes its result to register rd within the same cycle.
- R4: Opcode 0010011 performs the same funct3 operations using the sign-extended immediate in bits 31:20. funct3 000 is always an add. For funct3 101, bit 30 picks the arithmetic right shift.
- R5: A set-less-than operation writes 1 to rd when its comparison holds and 0 otherwise. It compares signed for funct3 010 and unsigned for funct3 011, in both R and I forms.
- R6: Shift amounts use only the low 5 bits of rs2 or of the immediate. Arithmetic right shifts fill with the sign bit, and logical shifts fill with zeros.
- R7: A word load (opcode 0000011, funct3 010) writes to rd the data memory word at address rs1 plus the sign-extended bits 31:20, taken modulo the memory depth.
- R8: A word store (opcode 0100011, funct3 010) writes rs2 to address rs1 plus the immediate {bits 31:25, bits 11:7}, sign-extended, and does not write any register.
- R9: Register x0 always reads as 0, and a write aimed at it leaves it at 0.
- R10: Any other opcode or funct3 combination changes neither the registers nor the data memory, and the PC still advances by 4. This covers branch 1100011, jal 1101111, jalr 1100111, lui 0110111, auipc 0010111, system 1110011, and sub-word loads and stores.
- R11: The load port writes only while `run` is 0. `ld_sel` value 0 targets instruction memory, 1 targets data memory and 2 targets the register file, at index `ld_addr`. A load request made while `run` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 executes one instruction per cycle, 0 freezes the core |
| ld_en | input | 1 | Load port write strobe |
| ld_sel | input | 2 | Load target: 0 instruction memory, 1 data memory, 2 register file |
| ld_addr | input | LD_AW (8) | Word index or register number for the load port |
| ld_data | input | XLEN (32) | Value written by the load port |
| dbg_addr | input | 5 | Register number to inspect |
| dbg_data | output | XLEN (32) | Contents of register `dbg_addr` |
| pc_o | output | XLEN (32) | Current program counter |

## Verification
Each check compares the state after a whole program has run, so the hardest case to reach is a specific instruction in a specific machine state. One example is a store whose negative offset is split across both immediate fields and wraps around the data memory, followed by a load from the same location. Another is an arithmetic shift of a negative value by an amount above 31. Directed machine-code programs set up these states through register and memory preloads. Seeded random straight-line programs mix ALU operations, loads and stores, so that results feed later operands. A bench-side instruction model predicts every register and the final PC.

// File: rtl/rv_sc_pkg.sv
package rv_sc_pkg;
   localparam logic [6:0] OPC_REG   = 7'b0110011;
   localparam logic [6:0] OPC_IMM   = 7'b0010011;
   localparam logic [6:0] OPC_LOAD  = 7'b0000011;
   localparam logic [6:0] OPC_STORE = 7'b0100011;
   localparam logic [2:0] F3_WORD   = 3'b010;

   typedef enum logic [3:0] {
      OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU,
      OP_XOR, OP_SRL, OP_SRA, OP_OR, OP_AND
   } alu_op_e;

   typedef struct packed {
      logic    reg_we;
      logic    mem_we;
      logic    use_imm;
      logic    imm_s;
      logic    wb_mem;
      alu_op_e op;
   } ctrl_t;

   localparam logic [1:0] LD_IMEM = 2'd0;
   localparam logic [1:0] LD_DMEM = 2'd1;
   localparam logic [1:0] LD_REGS = 2'd2;
endpackage

// File: rtl/rv_sc_decode.sv
module rv_sc_decode
   import rv_sc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [31:0]     instr,
   output ctrl_t           ctrl,
   output logic [XLEN-1:0] imm
);
   logic [6:0] opc;
   logic [2:0] f3;
   logic       alt;

   assign opc = instr[6:0];
   assign f3  = instr[14:12];
   assign alt = instr[30];

   function automatic alu_op_e pick_op(input logic [2:0] fn, input logic a);
      case (fn)
         3'b000:  return a ? OP_SUB : OP_ADD;
         3'b001:  return OP_SLL;
         3'b010:  return OP_SLT;
         3'b011:  return OP_SLTU;
         3'b100:  return OP_XOR;
         3'b101:  return a ? OP_SRA : OP_SRL;
         3'b110:  return OP_OR;
         default: return OP_AND;
      endcase
   endfunction

   always_comb begin
      ctrl    = '0;
      ctrl.op = OP_ADD;
      case (opc)
         OPC_REG: begin
            ctrl.reg_we = 1'b1;
            ctrl.op     = pick_op(f3, alt);
         end
         OPC_IMM: begin
            ctrl.reg_we  = 1'b1;
            ctrl.use_imm = 1'b1;
            ctrl.op      = pick_op(f3, alt && (f3 == 3'b101));
         end
         OPC_LOAD: begin
            if (f3 == F3_WORD) begin
               ctrl.reg_we  = 1'b1;
               ctrl.use_imm = 1'b1;
               ctrl.wb_mem  = 1'b1;
            end
         end
         OPC_STORE: begin
            if (f3 == F3_WORD) begin
               ctrl.mem_we  = 1'b1;
               ctrl.use_imm = 1'b1;
               ctrl.imm_s   = 1'b1;
            end
         end
         default: ctrl = ctrl;
      endcase
   end

   always_comb begin
      if (ctrl.imm_s)
         imm = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
      else
         imm = {{(XLEN-12){instr[31]}}, instr[31:20]};
   end
endmodule

// File: rtl/rv_sc_alu.sv
module rv_sc_alu
   import rv_sc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter bit BARREL_SHF = 1'b1
) (
   input  alu_op_e         op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] y
);
   localparam int SHW = $clog2(XLEN);

   if (XLEN < 16 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
      $error("rv_sc_alu: XLEN must be a power of two of at least 16");
   end

   logic [SHW-1:0]  amt;
   logic [XLEN-1:0] shl, shr;
   assign amt = b[SHW-1:0];

   function automatic logic [XLEN-1:0] flip(input logic [XLEN-1:0] v);
      for (int i = 0; i < XLEN; i++) flip[i] = v[XLEN-1-i];
   endfunction

   if (BARREL_SHF) begin : g_barrel
      logic            left, fill;
      logic [XLEN-1:0] stg [SHW+1];
      assign left   = (op == OP_SLL);
      assign fill   = (op == OP_SRA) & a[XLEN-1];
      assign stg[0] = left ? flip(a) : a;
      for (genvar k = 0; k < SHW; k++) begin : g_stage
         assign stg[k+1] = amt[k] ? {{(1 << k){fill}}, stg[k][XLEN-1:(1 << k)]}
                                  : stg[k];
      end
      assign shl = flip(stg[SHW]);
      assign shr = stg[SHW];
   end else begin : g_plain
      assign shl = a << amt;
      assign shr = (op == OP_SRA) ? XLEN'($signed(a) >>> amt) : (a >> amt);
   end

   always_comb begin
      case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_SLL:  y = shl;
         OP_SLT:  y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
         OP_SLTU: y = {{(XLEN-1){1'b0}}, a < b};
         OP_XOR:  y = a ^ b;
         OP_SRL,
         OP_SRA:  y = shr;
         OP_OR:   y = a | b;
         default: y = a & b;
      endcase
   end
endmodule

// File: rtl/rv_sc_regfile.sv
module rv_sc_regfile #(
   parameter int XLEN = 32,
   parameter int NREG = 32,
   localparam int AW  = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic [XLEN-1:0] wdata,
   input  logic [AW-1:0]   ra1,
   input  logic [AW-1:0]   ra2,
   input  logic [AW-1:0]   ra3,
   output logic [XLEN-1:0] rd1,
   output logic [XLEN-1:0] rd2,
   output logic [XLEN-1:0] rd3
);
   if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
      $error("rv_sc_regfile: NREG must be a power of two");
   end

   logic [XLEN-1:0] rows [NREG];
   assign rows[0] = '0;

   for (genvar g = 1; g < NREG; g++) begin : g_row
      logic [XLEN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        q <= '0;
         else if (we && waddr == AW'(g))    q <= wdata;
      end
      assign rows[g] = q;
   end

   assign rd1 = rows[ra1];
   assign rd2 = rows[ra2];
   assign rd3 = rows[ra3];

   p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr != '0) |=> rows[$past(waddr)] == $past(wdata));

   p_zero_row_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr == '0) |=> rd1 == '0 || ra1 != '0);
endmodule

// File: rtl/rv_sc_ram.sv
module rv_sc_ram #(
   parameter int W     = 32,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rv_sc_ram: DEPTH must be a power of two");
   end

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

   p_ram_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/rv_sc_core.sv
module rv_sc_core
   import rv_sc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NREG       = 32,
   parameter int IMEM_DEPTH = 64,
   parameter int DMEM_DEPTH = 64,
   parameter int LD_AW      = 8,
   parameter bit BARREL_SHF = 1'b1,
   localparam int RAW       = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             ld_en,
   input  logic [1:0]       ld_sel,
   input  logic [LD_AW-1:0] ld_addr,
   input  logic [XLEN-1:0]  ld_data,
   input  logic [RAW-1:0]   dbg_addr,
   output logic [XLEN-1:0]  dbg_data,
   output logic [XLEN-1:0]  pc_o
);
   localparam int IAW = $clog2(IMEM_DEPTH);
   localparam int DAW = $clog2(DMEM_DEPTH);

   if (XLEN != 32 || NREG != 32) begin : g_bad_arch
      $error("rv_sc_core: the instruction encoding fixes XLEN and NREG at 32");
   end
   if (LD_AW < IAW || LD_AW < DAW || LD_AW < RAW) begin : g_bad_ldaw
      $error("rv_sc_core: LD_AW too narrow for the storage arrays");
   end

   logic [XLEN-1:0] pc, instr, imm, rs1_v, rs2_v, opb, alu_y, dm_q, wb;
   ctrl_t           ctrl;
   logic            im_we, dm_we, rf_we, ld_ok;
   logic [DAW-1:0]  dm_wa;
   logic [XLEN-1:0] dm_wd, rf_wd;
   logic [RAW-1:0]  rf_wa;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pc <= '0;
      else if (run) pc <= pc + XLEN'(4);
   end
   assign pc_o = pc;

   assign ld_ok = ld_en && !run;
   assign im_we = ld_ok && ld_sel == LD_IMEM;

   rv_sc_ram #(.W(32), .DEPTH(IMEM_DEPTH)) u_imem (
      .clk(clk), .rst_n(rst_n), .we(im_we), .waddr(ld_addr[IAW-1:0]),
      .wdata(ld_data), .raddr(pc[IAW+1:2]), .rdata(instr));

   rv_sc_decode #(.XLEN(XLEN)) u_dec (.instr(instr), .ctrl(ctrl), .imm(imm));

   assign rf_we = run ? ctrl.reg_we : (ld_ok && ld_sel == LD_REGS);
   assign rf_wa = run ? instr[11:7] : ld_addr[RAW-1:0];
   assign rf_wd = run ? wb : ld_data;

   rv_sc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(rf_wa), .wdata(rf_wd),
      .ra1(instr[19:15]), .ra2(instr[24:20]), .ra3(dbg_addr),
      .rd1(rs1_v), .rd2(rs2_v), .rd3(dbg_data));

   assign opb = ctrl.use_imm ? imm : rs2_v;

   rv_sc_alu #(.XLEN(XLEN), .BARREL_SHF(BARREL_SHF)) u_alu (
      .op(ctrl.op), .a(rs1_v), .b(opb), .y(alu_y));

   assign dm_we = run ? ctrl.mem_we : (ld_ok && ld_sel == LD_DMEM);
   assign dm_wa = run ? alu_y[DAW-1:0] : ld_addr[DAW-1:0];
   assign dm_wd = run ? rs2_v : ld_data;

   rv_sc_ram #(.W(XLEN), .DEPTH(DMEM_DEPTH)) u_dmem (
      .clk(clk), .rst_n(rst_n), .we(dm_we), .waddr(dm_wa),
      .wdata(dm_wd), .raddr(alu_y[DAW-1:0]), .rdata(dm_q));

   assign wb = ctrl.wb_mem ? dm_q : alu_y;

   p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> pc == $past(pc) + XLEN'(4));
   p_pc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(pc));
   p_alu_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && (instr[6:0] == OPC_REG || instr[6:0] == OPC_IMM)) |-> rf_we);
   p_store_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && dm_we) |-> !rf_we);
   p_other_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && instr[6:0] != OPC_REG && instr[6:0] != OPC_IMM &&
       instr[6:0] != OPC_LOAD && instr[6:0] != OPC_STORE) |-> !rf_we && !dm_we);
   p_load_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> !im_we);
endmodule

// File: tb/sim_rv_sc_core.sv
module sim_rv_sc_core;
   localparam int DMD = 64;
   localparam int IMD = 64;

   logic        clk = 1'b0, rst_n = 1'b0, run = 1'b0, ld_en = 1'b0;
   logic [1:0]  ld_sel = '0;
   logic [7:0]  ld_addr = '0;
   logic [31:0] ld_data = '0;
   logic [4:0]  dbg_addr = '0;
   logic [31:0] dbg_data, pc_o;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   logic [31:0] mrf  [32];
   logic [31:0] mdm  [DMD];
   logic [31:0] prog [IMD];
   int          plen;

   rv_sc_core u0 (.clk(clk), .rst_n(rst_n), .run(run), .ld_en(ld_en), .ld_sel(ld_sel),
                  .ld_addr(ld_addr), .ld_data(ld_data), .dbg_addr(dbg_addr),
                  .dbg_data(dbg_data), .pc_o(pc_o));

   always #10 clk = ~clk;

   initial begin
      #(20 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   function automatic logic [31:0] e_r(input logic [6:0] f7, input int rs2, input int rs1,
                                       input logic [2:0] f3, input int rd);
      return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
   endfunction
   function automatic logic [31:0] e_i(input logic [11:0] im, input int rs1, input logic [2:0] f3,
                                       input int rd, input logic [6:0] op);
      return {im, 5'(rs1), f3, 5'(rd), op};
   endfunction
   function automatic logic [31:0] e_s(input logic [11:0] im, input int rs2, input int rs1,
                                       input logic [2:0] f3);
      return {im[11:5], 5'(rs2), 5'(rs1), f3, im[4:0], 7'b0100011};
   endfunction

   function automatic logic [31:0] ref_alu(input logic [2:0] f3, input bit alt,
                                           input logic [31:0] a, input logic [31:0] b);
      case (f3)
         3'd0: return alt ? a - b : a + b;
         3'd1: return a << b[4:0];
         3'd2: return {31'd0, $signed(a) < $signed(b)};
         3'd3: return {31'd0, a < b};
         3'd4: return a ^ b;
         3'd5: return alt ? 32'($signed(a) >>> b[4:0]) : a >> b[4:0];
         3'd6: return a | b;
         default: return a & b;
      endcase
   endfunction

   task automatic model_step(input logic [31:0] w);
      logic [31:0] iim, sim, res, a;
      bit wr;
      iim = {{20{w[31]}}, w[31:20]};
      sim = {{20{w[31]}}, w[31:25], w[11:7]};
      a   = mrf[w[19:15]];
      wr  = 1'b0;
      res = '0;
      case (w[6:0])
         7'b0110011: begin res = ref_alu(w[14:12], w[30], a, mrf[w[24:20]]); wr = 1'b1; end
         7'b0010011: begin
            res = ref_alu(w[14:12], w[30] && w[14:12] == 3'd5, a, iim); wr = 1'b1;
         end
         7'b0000011: if (w[14:12] == 3'd2) begin
            res = mdm[5'(0) + 6'(a + iim)]; wr = 1'b1;
         end
         7'b0100011: if (w[14:12] == 3'd2) mdm[6'(a + sim)] = mrf[w[24:20]];
         default: wr = 1'b0;
      endcase
      if (wr && w[11:7] != 5'd0) mrf[w[11:7]] = res;
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      run = 1'b0; ld_en = 1'b0; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic ld(input logic [1:0] sel, input int addr, input logic [31:0] data);
      @(negedge clk);
      ld_en = 1'b1; ld_sel = sel; ld_addr = 8'(addr); ld_data = data;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic clear_model();
      for (int i = 0; i < 32; i++) mrf[i] = '0;
      for (int i = 0; i < DMD; i++) mdm[i] = '0;
      for (int i = 0; i < IMD; i++) prog[i] = '0;
      plen = 0;
   endtask

   task automatic add(input logic [31:0] w);
      prog[plen] = w;
      plen++;
   endtask

   task automatic run_prog(input string tag, input bit poke);
      do_reset();
      for (int r = 1; r < 32; r++) ld(2'd2, r, mrf[r]);
      for (int a = 0; a < DMD; a++) ld(2'd1, a, mdm[a]);
      for (int a = 0; a < IMD; a++) ld(2'd0, a, prog[a]);
      @(negedge clk);
      run = 1'b1;
      if (poke) begin
         ld_en = 1'b1; ld_sel = 2'd2; ld_addr = 8'd31; ld_data = 32'hDEAD_0031;
      end
      for (int i = 0; i < plen; i++) begin
         @(posedge clk);
         #1 ld_en = 1'b0;
      end
      @(negedge clk);
      run = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = 0; i < plen; i++) model_step(prog[i]);
      chk({tag, " pc (R1)"}, pc_o, 32'(4 * plen));
      for (int r = 0; r < 32; r++) begin
         dbg_addr = 5'(r);
         #1 chk($sformatf("%s x%0d", tag, r), dbg_data, mrf[r]);
      end
   endtask

   initial begin
      void'($urandom(32'h1F2E_3D4C));
      do_reset();
      @(negedge clk);
      chk("R1 reset pc", pc_o, 32'd0);
      for (int r = 0; r < 32; r++) begin
         dbg_addr = 5'(r);
         #1 chk($sformatf("R1 reset x%0d", r), dbg_data, 32'd0);
      end

      // R2 R3: add and sub chain
      clear_model();
      mrf[1] = 32'd5; mrf[2] = 32'd7; mrf[3] = 32'd9; mrf[4] = 32'd11;
      add(32'h002082B3); add(32'h005182B3); add(32'h005202B3);
      add(32'h401282B3); add(32'h403282B3); add(32'h404282B3);
      run_prog("R2 R3 add-sub", 1'b0);

      // R4 R5: immediates and compares
      clear_model();
      mrf[2] = 32'd2; mrf[3] = 32'd3;
      add(32'h00310533); add(32'h40250533); add(32'h00A50513); add(32'hFF650513);
      add(32'h00052093); add(32'h00A52113);
      add(e_i(12'hFFF, 10, 3'd3, 7, 7'b0010011));
      add(e_i(12'hFFF, 10, 3'd2, 8, 7'b0010011));
      add(e_r(7'h00, 9, 10, 3'd2, 11));
      mrf[9] = 32'hFFFF_FFF0;
      add(e_r(7'h00, 9, 10, 3'd3, 12));
      run_prog("R4 R5 imm-slt", 1'b0);

      // R2: logic ops
      clear_model();
      mrf[2] = 32'd2; mrf[3] = 32'd3;
      add(32'h003172B3); add(32'h00316333); add(32'h00A17293); add(32'h00A16313);
      add(e_r(7'h00, 3, 2, 3'd4, 7)); add(e_i(12'h8F0, 3, 3'd4, 8, 7'b0010011));
      run_prog("R2 logic", 1'b0);

      // R7: word loads incl. negative offset
      clear_model();
      mrf[7] = 32'd3; mdm[7] = 32'd3; mdm[10] = 32'hE; mdm[1] = 32'hCAFE_0001;
      add(32'h0073A303); add(32'h00030313);
      add(e_i(12'hFFE, 7, 3'd2, 9, 7'b0000011));
      run_prog("R7 load", 1'b0);

      // R8: store then load, plus split negative offset that wraps
      clear_model();
      mrf[14] = 32'd5; mrf[2] = 32'd4; mrf[15] = 32'h1234_5678;
      add(32'h00E12423); add(32'h00812603); add(32'h00060613);
      add(e_s(12'hFD8, 15, 2, 3'd2));
      add(e_i(12'hFD8, 2, 3'd2, 13, 7'b0000011));
      add(e_i(12'd28, 0, 3'd2, 16, 7'b0000011));
      run_prog("R8 store", 1'b0);

      // R6: shifts with oversized amounts and negative data
      clear_model();
      mrf[1] = 32'h8000_0010; mrf[2] = 32'd35;
      add(e_r(7'h00, 2, 1, 3'd1, 3)); add(e_r(7'h00, 2, 1, 3'd5, 4));
      add(e_r(7'h20, 2, 1, 3'd5, 5)); add(e_i(12'h01F, 1, 3'd1, 6, 7'b0010011));
      add(e_i(12'h404, 1, 3'd5, 7, 7'b0010011)); add(e_i(12'h004, 1, 3'd5, 8, 7'b0010011));
      run_prog("R6 shift", 1'b0);

      // R9: writes to x0
      clear_model();
      mrf[2] = 32'd7;
      add(e_i(12'd5, 0, 3'd0, 0, 7'b0010011)); add(e_r(7'h00, 2, 2, 3'd0, 0));
      add(e_r(7'h00, 0, 0, 3'd0, 1)); add(e_i(12'd1, 0, 3'd0, 3, 7'b0010011));
      run_prog("R9 x0", 1'b0);

      // R10: opcodes outside scope act as no-ops
      clear_model();
      for (int r = 1; r < 32; r++) mrf[r] = 32'(r * 3);
      mdm[12] = 32'h5555_AAAA; mrf[4] = 32'd12;
      add(32'h00208463); add(32'h008000EF); add(e_i(12'd0, 1, 3'd0, 5, 7'b1100111));
      add(32'h123452B7); add(32'h00001317); add(32'h00000073);
      add(e_i(12'd0, 4, 3'd0, 7, 7'b0000011)); add(e_s(12'd0, 1, 4, 3'd0));
      add(e_i(12'd0, 4, 3'd2, 8, 7'b0000011)); add(e_r(7'h00, 2, 1, 3'd0, 9));
      run_prog("R10 other", 1'b0);

      // R11: load request while running is ignored
      clear_model();
      mrf[31] = 32'h0BAD_F00D; mrf[1] = 32'd1;
      add(e_i(12'd2, 1, 3'd0, 2, 7'b0010011)); add(e_r(7'h00, 2, 1, 3'd0, 3));
      run_prog("R11 locked", 1'b1);

      // R2 R3 R4 R7 R8: seeded random straight-line programs
      for (int p = 0; p < 30; p++) begin
         clear_model();
         for (int r = 1; r < 32; r++) mrf[r] = $urandom;
         for (int a = 0; a < DMD; a++) mdm[a] = $urandom;
         for (int i = 0; i < 24; i++) begin
            int kind = $urandom_range(0, 3);
            logic [2:0] f3 = 3'($urandom);
            bit alt = 1'($urandom) && (f3 == 3'd0 || f3 == 3'd5);
            int rd = $urandom_range(0, 31), rs1 = $urandom_range(0, 31);
            int rs2 = $urandom_range(0, 31);
            logic [11:0] im = 12'($urandom);
            case (kind)
               0: add(e_r(alt ? 7'h20 : 7'h00, rs2, rs1, f3, rd));
               1: begin
                  if (f3 == 3'd1) im[11:5] = 7'h00;
                  if (f3 == 3'd5) im[11:5] = alt ? 7'h20 : 7'h00;
                  add(e_i(im, rs1, f3, rd, 7'b0010011));
               end
               2: add(e_i(im, rs1, 3'd2, rd, 7'b0000011));
               default: add(e_s(im, rs2, rs1, 3'd2));
            endcase
         end
         run_prog($sformatf("R2 R3 R4 R7 R8 random %0d", p), 1'b0);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule